// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets any processor in a small multicore cluster raise an interrupt on any other processor and hand it a 16-bit message along with it. Each core owns two 32-bit registers on a simple register bus: a control register that it writes to send or acknowledge, and a status register that records the last message delivered to it. Each core has one level-sensitive interrupt output. Its level follows that core's pending flag.

A sender writes its own control register. The word names a destination core and carries a payload, with a command bit to deliver it. The destination's status then shows a pending flag, the sender's index and the payload, and its interrupt line rises. The receiver reads its status and then writes the acknowledge bit to its own control register. This clears the pending flag and drops the line. Only one message is held per core, so a later message replaces an earlier one. The core count is a parameter with a default of 4. A core count above the supported maximum, or below one, stops elaboration.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset, and while reset is held, every control and status register reads as zero and every interrupt output is low.
- R2: Byte address bit 2 selects control (0) or status (1), and bits 3 and up give the core index. An index at or above the core count reads as zero, and writes to it have no effect on any register or interrupt.
- R3: A write to a core's control register stores the full 32-bit word. A read of that register returns it.
- R4: A control word with bit 30 (send) set carries a destination in bits 29:16. It loads the destination's status with bit 31 = 0, bit 30 (pending) = 1, bits 29:16 = the writer's index and bits 15:0 = the word's bits 15:0. The destination's interrupt output is high from the clock edge that takes the write.
- R5: A control word with bit 31 (acknowledge) set clears the writer's own pending bit, and its interrupt output falls on that edge. The writer's source and payload fields are kept.
- R6: When send and acknowledge are both set and the destination is the writer itself, the send is applied before the acknowledge. Pending ends at 0 and the interrupt output is low, while source and payload hold the new message.
- R7: A send whose destination is at or above the core count changes no status and raises no interrupt. The control word is still stored.
- R8: Writes to a status register have no effect. Status changes only through control writes.
- R9: A send to a core that already has a message pending overwrites that core's source and payload. The interrupt output stays high.
- R10: While the read enable is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | NUM_CORES | Per-core interrupt level |

## Verification
The assertions assume that there is at most one write per cycle, on a single write strobe. They also assume that address and data are stable around the clock edge that takes the write. The bench drives every access on the falling edge and holds the write strobe for exactly one rising edge, so both assumptions always hold. Destination fields beyond the core count, and core indices beyond it, are exercised on purpose. The assertions state the expected behaviour for these cases rather than assuming them away.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W      = 32;
  localparam int ACK_BIT     = 31;
  localparam int SEND_BIT    = 30;
  localparam int PEND_BIT    = 30;
  localparam int ID_LSB      = 16;
  localparam int ID_W        = 14;
  localparam int PAY_W       = 16;
  localparam int REG_SEL_BIT = 2;
  localparam int CORE_LSB    = 3;

  typedef logic [ID_W-1:0]   core_id_t;
  typedef logic [PAY_W-1:0]  payload_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic     pend;
    core_id_t src;
    payload_t pay;
  } stat_t;

  function automatic word_t stat_to_word(stat_t s);
    return {1'b0, s};
  endfunction
endpackage

// File: rtl/ipi_bus_dec.sv
module ipi_bus_dec
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = ADDR_W - CORE_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  word_t                wdata_i,
  output logic [NUM_CORES-1:0] ctrl_we_o,
  output logic [NUM_CORES-1:0] send_o,
  output logic [NUM_CORES-1:0] ack_o,
  output core_id_t             src_o,
  output payload_t             pay_o,
  output logic [NUM_CORES-1:0] rd_sel_o,
  output logic                 rd_stat_o
);
  logic [IDX_W-1:0] idx;
  logic             idx_ok, is_stat, wr_ctrl, dst_ok, send_cmd;
  core_id_t         dst;
  logic             unused_addr;

  assign idx         = addr_i[ADDR_W-1:CORE_LSB];
  assign is_stat     = addr_i[REG_SEL_BIT];
  assign unused_addr = ^addr_i[REG_SEL_BIT-1:0];
  assign idx_ok      = int'(idx) < NUM_CORES;
  assign wr_ctrl     = wr_en_i & ~is_stat & idx_ok;
  assign dst         = wdata_i[ID_LSB +: ID_W];
  assign dst_ok      = int'(dst) < NUM_CORES;
  assign send_cmd    = wr_ctrl & wdata_i[SEND_BIT] & dst_ok;
  assign src_o       = ID_W'(idx);
  assign pay_o       = wdata_i[PAY_W-1:0];
  assign rd_stat_o   = is_stat;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    assign ctrl_we_o[k] = wr_ctrl & (idx == IDX_W'(k));
    assign ack_o[k]     = ctrl_we_o[k] & wdata_i[ACK_BIT];
    assign send_o[k]    = send_cmd & (dst == ID_W'(k));
    assign rd_sel_o[k]  = rd_en_i & idx_ok & (idx == IDX_W'(k));
  end

  AST_SEND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(send_o)); // R4
  AST_BAD_DST_NO_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !dst_ok) |-> (send_o == '0)); // R7
  AST_STAT_WR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_stat) |-> (ctrl_we_o == '0 && send_o == '0)); // R8
  AST_BAD_IDX_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_ok |-> (ctrl_we_o == '0 && send_o == '0 && rd_sel_o == '0)); // R2
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ctrl_we_i,
  input  word_t    wdata_i,
  input  logic     send_i,
  input  logic     ack_i,
  input  core_id_t src_i,
  input  payload_t pay_i,
  output word_t    ctrl_o,
  output word_t    stat_o,
  output logic     irq_o
);
  word_t ctrl_q;
  stat_t stat_q, stat_d;
  logic  irq_q;

  // send first, then ack: self-send with ack nets pending = 0
  always_comb begin
    stat_d = stat_q;
    if (send_i) stat_d = '{pend: 1'b1, src: src_i, pay: pay_i};
    if (ack_i)  stat_d.pend = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      stat_q <= stat_d;
      irq_q  <= stat_d.pend;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_to_word(stat_q);
  assign irq_o  = irq_q;

  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == stat_q.pend); // R4
  AST_SEND_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !ack_i) |=> (stat_q.pend && stat_q.src == $past(src_i) && stat_q.pay == $past(pay_i))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!stat_q.pend && !irq_q)); // R5
  AST_ACK_KEEPS_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !send_i) |=> ($stable(stat_q.src) && $stable(stat_q.pay))); // R5
  AST_SELF_SEND_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && ack_i) |=> (!stat_q.pend && stat_q.pay == $past(pay_i))); // R6
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!send_i && !ack_i) |=> $stable(stat_q)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0]             sel_i,
  input  logic                             stat_i,
  input  logic [NUM_CORES-1:0][WORD_W-1:0] ctrl_i,
  input  logic [NUM_CORES-1:0][WORD_W-1:0] stat_w_i,
  output word_t                            rdata_o
);
  logic [NUM_CORES:0][WORD_W-1:0] acc;

  assign acc[0] = '0;
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_or
    assign acc[k+1] = acc[k] | ({WORD_W{sel_i[k]}} & (stat_i ? stat_w_i[k] : ctrl_i[k]));
  end
  assign rdata_o = acc[NUM_CORES];
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          wdata_i,
  input  logic                 rd_en_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cfg
    $error("ipi_ctrl: NUM_CORES out of supported range");
  end

  logic [NUM_CORES-1:0]             ctrl_we, send, ack, rd_sel;
  logic                             rd_stat;
  core_id_t                         src;
  payload_t                         pay;
  logic [NUM_CORES-1:0][WORD_W-1:0] ctrl_w, stat_w;

  ipi_bus_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) i_dec (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .ctrl_we_o(ctrl_we), .send_o(send), .ack_o(ack),
    .src_o(src), .pay_o(pay), .rd_sel_o(rd_sel), .rd_stat_o(rd_stat)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    ipi_core_slot i_slot (
      .clk_i, .rst_ni,
      .ctrl_we_i(ctrl_we[k]), .wdata_i,
      .send_i(send[k]), .ack_i(ack[k]),
      .src_i(src), .pay_i(pay),
      .ctrl_o(ctrl_w[k]), .stat_o(stat_w[k]), .irq_o(irq_o[k])
    );
  end

  ipi_rd_mux #(.NUM_CORES(NUM_CORES)) i_mux (
    .sel_i(rd_sel), .stat_i(rd_stat),
    .ctrl_i(ctrl_w), .stat_w_i(stat_w), .rdata_o
  );

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0)); // R10
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> $stable(irq_o)); // R8
endmodule

// File: tb/test_ipi_ctrl.sv
`timescale 1ns/1ps
module test_ipi_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  ipi_ctrl i_ipi_ctrl (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o, .irq_o
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  irq;    // expected irq after the access
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h4002_1234, 4'b0100, 4'd4},  // R4 core0 -> core2
    '{1'b0, 8'h00, 32'h4002_1234, 4'b0100, 4'd3},  // R3
    '{1'b0, 8'h14, 32'h4000_1234, 4'b0100, 4'd4},  // R4
    '{1'b1, 8'h08, 32'h4002_00AB, 4'b0100, 4'd9},  // R9 core1 -> core2
    '{1'b0, 8'h14, 32'h4001_00AB, 4'b0100, 4'd9},  // R9
    '{1'b1, 8'h14, 32'h0000_0000, 4'b0100, 4'd8},  // R8 status write
    '{1'b0, 8'h14, 32'h4001_00AB, 4'b0100, 4'd8},  // R8
    '{1'b1, 8'h10, 32'h8000_0000, 4'b0000, 4'd5},  // R5 core2 ack
    '{1'b0, 8'h14, 32'h0001_00AB, 4'b0000, 4'd5},  // R5
    '{1'b1, 8'h18, 32'hC003_BEEF, 4'b0000, 4'd6},  // R6 self send + ack
    '{1'b0, 8'h1C, 32'h0003_BEEF, 4'b0000, 4'd6},  // R6
    '{1'b1, 8'h08, 32'h4004_5555, 4'b0000, 4'd7},  // R7 dst 4
    '{1'b0, 8'h08, 32'h4004_5555, 4'b0000, 4'd7},  // R7
    '{1'b0, 8'h04, 32'h0000_0000, 4'b0000, 4'd7},  // R7 no alias on core0
    '{1'b1, 8'h20, 32'h4000_7777, 4'b0000, 4'd2},  // R2 core index 4
    '{1'b0, 8'h04, 32'h0000_0000, 4'b0000, 4'd2},  // R2
    '{1'b0, 8'h20, 32'h0000_0000, 4'b0000, 4'd2},  // R2
    '{1'b1, 8'h00, 32'hC001_0042, 4'b0010, 4'd4},  // R4 ack + send elsewhere
    '{1'b0, 8'h0C, 32'h4000_0042, 4'b0010, 4'd4},  // R4
    '{1'b1, 8'h18, 32'h4000_0009, 4'b0011, 4'd4},  // R4 core3 -> core0
    '{1'b0, 8'h04, 32'h4003_0009, 4'b0011, 4'd4}   // R4
  };

  function automatic string rname(logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    // R1: state during reset
    check(irq_o == 4'b0, "R1", "irq in reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    // R1: state after reset
    for (int k = 0; k < 8; k++) begin
      do_read(8'(k * 4), rd);
      check(rd == 32'h0, "R1", "reg after reset", rd, 32'h0);
    end
    check(irq_o == 4'b0, "R1", "irq after reset", 32'(irq_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        do_write(VECS[i].addr, VECS[i].data);
      end else begin
        do_read(VECS[i].addr, rd);
        check(rd == VECS[i].data, rname(VECS[i].req), "read", rd, VECS[i].data);
      end
      check(irq_o == VECS[i].irq, rname(VECS[i].req), "irq", 32'(irq_o), 32'(VECS[i].irq));
    end

    // R10: read enable low gives zero even on a nonzero register
    @(negedge clk_i);
    addr_i = 8'h04; rd_en_i = 1'b0;
    #1 check(rdata_o == 32'h0, "R10", "rdata idle", rdata_o, 32'h0);

    // R9: repeated send while pending keeps line high, updates payload
    do_write(8'h08, 32'h4000_0101);
    check(irq_o == 4'b0011, "R9", "irq", 32'(irq_o), 32'h3);
    do_read(8'h04, rd);
    check(rd == 32'h4001_0101, "R9", "status0", rd, 32'h4001_0101);

    // R5: ack from core1 only clears core1
    do_write(8'h08, 32'h8000_0000);
    check(irq_o == 4'b0001, "R5", "irq", 32'(irq_o), 32'h1);

    // R1: mid-run reset clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check(irq_o == 4'b0, "R1", "irq on reset", 32'(irq_o), 32'h0);
    do_read(8'h04, rd);
    check(rd == 32'h0, "R1", "status0 in reset", rd, 32'h0);
    do_read(8'h00, rd);
    check(rd == 32'h0, "R1", "ctrl0 in reset", rd, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_read(8'h14, rd);
    check(rd == 32'h0, "R1", "status2 after reset", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule